// File: doc/BRIEF.md
# Latched Fault Status Register

This block keeps the diagnostic flags for three supply faults: output overload, overtemperature and low input power. It also holds the control word that sets the regulated output voltage and decides how the output recovers from a fault. Raw fault levels come from the analog protection circuits. A status-read strobe and a register write port come from the host-side bus engine, which is not part of this block. An undervoltage-lockout level comes from the supply monitor.

Each fault has its own three-state latch. `CLEAR` moves to `ACTIVE` when the cause is sampled high. `ACTIVE` moves to `AWAIT_READ` when the cause is sampled low. `AWAIT_READ` moves back to `ACTIVE` if the cause returns, and to `CLEAR` on a read. The status flag is high in every state except `CLEAR`. When a latch leaves `ACTIVE`, it sends a release pulse to the control registers. If the matching recovery-policy bit is set, that pulse wipes the voltage-select field, so the output stays off until the host writes a new value.

Top module: `fault_status_reg`

## Requirements
- R1: After reset with no fault present, `st_ovl`, `st_ovt` and `st_png` are 0, `vsel` is 0, `fault_n` is 1 and `pwr_en` is 0.
- R2: A fault cause sampled high at a clock edge makes its status flag read 1 after that edge.
- R3: A status flag stays at 1 until a read strobe is sampled at an edge after its cause was seen low. It reads 0 after that edge.
- R4: A read strobe sampled while the cause is still high does not clear the flag. This includes the edge at which the cause is first seen low.
- R5: With overload policy bit `wr_olr` = 1 written, the edge at which a present overload is first seen low clears `vsel` to 0. `vsel` stays 0 until the host writes it again.
- R6: With overload policy 0, `vsel` is kept through an overload. `pwr_en` is back to 1 as soon as the overload timer enable `ol_out_en` is 1 again.
- R7: Thermal policy bit `wr_therm` acts on `vsel` in the same way at the end of an overtemperature. `pwr_en` is 0 whenever `ovt_raw` is 1.
- R8: While `uvlo` is 1, writes are ignored, `vsel` and both policy bits are held at 0, and read strobes have no effect.
- R9: `fault_n` is 0 exactly while the low-input-power flag `st_png` is 1.
- R10: `pwr_en` = (`vsel` != 0) and not `ovt_raw` and `ol_out_en`, without a clock cycle of delay.
- R11: When a policy-driven wipe and a host write fall on the same edge, `vsel` becomes 0. The policy bits still take the written values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ovl_raw | input | 1 | Raw overload level |
| ovt_raw | input | 1 | Raw overtemperature level |
| png_raw | input | 1 | Raw low-input-power level |
| ol_out_en | input | 1 | Output enable from the overload pulse timer |
| uvlo | input | 1 | Undervoltage lockout, active high |
| rd_stb | input | 1 | Status-read strobe |
| wr_en | input | 1 | Control-register write strobe |
| wr_vsel | input | VSEL_W | Voltage-select value to write |
| wr_olr | input | 1 | Overload policy to write (1 = wipe on release) |
| wr_therm | input | 1 | Thermal policy to write (1 = wipe on release) |
| st_ovl | output | 1 | Overload flag |
| st_ovt | output | 1 | Overtemperature flag |
| st_png | output | 1 | Low-input-power flag |
| vsel | output | VSEL_W | Voltage-select field |
| fault_n | output | 1 | Fault pin, active low |
| pwr_en | output | 1 | Power-stage enable |

## Verification
The bench builds the block with `VSEL_W` at its default of 4, so every nonzero voltage code can enable the output and the full field is visible in a wipe. The three latches share one generated module. Directed sequences therefore exercise each fault once. A long random phase then drives reads, writes, lockout and fault levels together. That phase reaches the combined cases: a wipe on the same edge as a write, a fault returning while its latch waits for a read, and a read arriving in the release cycle.

// File: rtl/fs_pkg.sv
package fs_pkg;
    typedef enum logic [1:0] {
        FL_CLEAR      = 2'd0,
        FL_ACTIVE     = 2'd1,
        FL_AWAIT_READ = 2'd2
    } fl_state_t;

    localparam int NUM_FAULTS = 3;
    localparam int FIDX_OVL   = 0;
    localparam int FIDX_OVT   = 1;
    localparam int FIDX_PNG   = 2;
endpackage

// File: rtl/fs_fault_latch.sv
module fs_fault_latch
    import fs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cause,
    input  logic rd,
    output logic flag,
    output logic release_p
);
    fl_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FL_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        release_p = 1'b0;
        unique case (state_q)
            FL_CLEAR: begin
                if (cause) state_d = FL_ACTIVE;
            end
            FL_ACTIVE: begin
                if (!cause) begin
                    state_d   = FL_AWAIT_READ;
                    release_p = 1'b1;
                end
            end
            FL_AWAIT_READ: begin
                if (cause)   state_d = FL_ACTIVE;
                else if (rd) state_d = FL_CLEAR;
            end
            default: state_d = FL_CLEAR;
        endcase
    end

    assign flag = (state_q != FL_CLEAR);
endmodule

// File: rtl/fs_ctrl_regs.sv
module fs_ctrl_regs #(
    parameter int VSEL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uvlo,
    input  logic              wr_en,
    input  logic [VSEL_W-1:0] wr_vsel,
    input  logic              wr_olr,
    input  logic              wr_therm,
    input  logic              rel_ovl,
    input  logic              rel_ovt,
    output logic [VSEL_W-1:0] vsel_q,
    output logic              olr_q,
    output logic              therm_q
);
    localparam logic [VSEL_W-1:0] VSEL_OFF = '0;

    logic wipe;
    assign wipe = (rel_ovl && olr_q) || (rel_ovt && therm_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vsel_q  <= VSEL_OFF;
            olr_q   <= 1'b0;
            therm_q <= 1'b0;
        end else if (uvlo) begin
            vsel_q  <= VSEL_OFF;
            olr_q   <= 1'b0;
            therm_q <= 1'b0;
        end else begin
            if (wr_en) begin
                olr_q   <= wr_olr;
                therm_q <= wr_therm;
            end
            if (wipe)       vsel_q <= VSEL_OFF;
            else if (wr_en) vsel_q <= wr_vsel;
        end
    end
endmodule

// File: rtl/fault_status_reg.sv
module fault_status_reg
    import fs_pkg::*;
#(
    parameter int VSEL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ovl_raw,
    input  logic              ovt_raw,
    input  logic              png_raw,
    input  logic              ol_out_en,
    input  logic              uvlo,
    input  logic              rd_stb,
    input  logic              wr_en,
    input  logic [VSEL_W-1:0] wr_vsel,
    input  logic              wr_olr,
    input  logic              wr_therm,
    output logic              st_ovl,
    output logic              st_ovt,
    output logic              st_png,
    output logic [VSEL_W-1:0] vsel,
    output logic              fault_n,
    output logic              pwr_en
);
    logic [NUM_FAULTS-1:0] causes;
    logic [NUM_FAULTS-1:0] flags;
    logic [NUM_FAULTS-1:0] releases;
    logic                  rd_ok;
    logic                  olr_q;
    logic                  therm_q;

    assign causes = {png_raw, ovt_raw, ovl_raw};
    assign rd_ok  = rd_stb && !uvlo;

    for (genvar i = 0; i < NUM_FAULTS; i++) begin : g_latch
        fs_fault_latch u_latch (
            .clk       (clk),
            .rst_n     (rst_n),
            .cause     (causes[i]),
            .rd        (rd_ok),
            .flag      (flags[i]),
            .release_p (releases[i])
        );
    end

    fs_ctrl_regs #(.VSEL_W(VSEL_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .uvlo     (uvlo),
        .wr_en    (wr_en),
        .wr_vsel  (wr_vsel),
        .wr_olr   (wr_olr),
        .wr_therm (wr_therm),
        .rel_ovl  (releases[FIDX_OVL]),
        .rel_ovt  (releases[FIDX_OVT]),
        .vsel_q   (vsel),
        .olr_q    (olr_q),
        .therm_q  (therm_q)
    );

    assign st_ovl  = flags[FIDX_OVL];
    assign st_ovt  = flags[FIDX_OVT];
    assign st_png  = flags[FIDX_PNG];
    assign fault_n = !flags[FIDX_PNG];
    assign pwr_en  = (|vsel) && !ovt_raw && ol_out_en;
endmodule

// File: rtl/fs_checker.sv
module fs_checker #(
    parameter int VSEL_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ovl_raw,
    input logic              ovt_raw,
    input logic              png_raw,
    input logic              uvlo,
    input logic              rd_stb,
    input logic              st_ovl,
    input logic              st_png,
    input logic [VSEL_W-1:0] vsel,
    input logic              fault_n,
    input logic              pwr_en,
    input logic              olr_q
);
    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_raw |=> st_ovl); // R2

    AST_FLAG_HOLDS_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (st_ovl && !rd_stb) |=> st_ovl); // R3

    AST_READ_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_png && png_raw) |=> st_png); // R4

    AST_OVL_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_ovl && $past(ovl_raw) && !ovl_raw && olr_q) |=> (vsel == '0)); // R5

    AST_OVT_POWER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ovt_raw |-> !pwr_en); // R7

    AST_LOCKOUT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo |=> (vsel == '0)); // R8

    AST_PNG_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        png_raw |=> !fault_n); // R9
endmodule

bind fault_status_reg fs_checker #(.VSEL_W(VSEL_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ovl_raw (ovl_raw),
    .ovt_raw (ovt_raw),
    .png_raw (png_raw),
    .uvlo    (uvlo),
    .rd_stb  (rd_stb),
    .st_ovl  (st_ovl),
    .st_png  (st_png),
    .vsel    (vsel),
    .fault_n (fault_n),
    .pwr_en  (pwr_en),
    .olr_q   (olr_q)
);

// File: tb/tb_fault_status_reg.sv
module tb_fault_status_reg;
    localparam int VW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ovl_raw = 0, ovt_raw = 0, png_raw = 0, ol_out_en = 1, uvlo = 0;
    logic rd_stb = 0, wr_en = 0, wr_olr = 0, wr_therm = 0;
    logic [VW-1:0] wr_vsel = '0;
    logic st_ovl, st_ovt, st_png, fault_n, pwr_en;
    logic [VW-1:0] vsel;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural reference: 0 = no flag, 1 = cause seen, 2 = waiting for a read
    int m_st [3];
    int m_vsel = 0;
    bit m_olr = 0, m_therm = 0;

    always #2 clk = ~clk;

    fault_status_reg #(.VSEL_W(VW)) dut (
        .clk(clk), .rst_n(rst_n), .ovl_raw(ovl_raw), .ovt_raw(ovt_raw),
        .png_raw(png_raw), .ol_out_en(ol_out_en), .uvlo(uvlo), .rd_stb(rd_stb),
        .wr_en(wr_en), .wr_vsel(wr_vsel), .wr_olr(wr_olr), .wr_therm(wr_therm),
        .st_ovl(st_ovl), .st_ovt(st_ovt), .st_png(st_png), .vsel(vsel),
        .fault_n(fault_n), .pwr_en(pwr_en)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) m_st[i] <= 0;
            m_vsel <= 0; m_olr <= 0; m_therm <= 0;
        end else begin
            bit c [3];
            bit rd, wipe;
            c[0] = ovl_raw; c[1] = ovt_raw; c[2] = png_raw;
            rd = rd_stb && !uvlo;
            wipe = (m_st[0] == 1 && !c[0] && m_olr) || (m_st[1] == 1 && !c[1] && m_therm);
            for (int i = 0; i < 3; i++) begin
                if (m_st[i] == 0 && c[i]) m_st[i] <= 1;
                else if (m_st[i] == 1 && !c[i]) m_st[i] <= 2;
                else if (m_st[i] == 2 && c[i]) m_st[i] <= 1;
                else if (m_st[i] == 2 && rd) m_st[i] <= 0;
            end
            if (uvlo) begin
                m_vsel <= 0; m_olr <= 0; m_therm <= 0;
            end else begin
                if (wr_en) begin m_olr <= wr_olr; m_therm <= wr_therm; end
                if (wipe) m_vsel <= 0;
                else if (wr_en) m_vsel <= int'(wr_vsel);
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 st_ovl", int'(st_ovl), int'(m_st[0] != 0));
            chk("R3 st_ovt", int'(st_ovt), int'(m_st[1] != 0));
            chk("R3 st_png", int'(st_png), int'(m_st[2] != 0));
            chk("R5 vsel", int'(vsel), m_vsel);
            chk("R9 fault_n", int'(fault_n), int'(m_st[2] == 0));
            chk("R10 pwr_en", int'(pwr_en), int'(m_vsel != 0 && !ovt_raw && ol_out_en));
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic write(int v, bit olr, bit th);
        wr_en = 1; wr_vsel = VW'(v); wr_olr = olr; wr_therm = th;
        tick();
        wr_en = 0;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(); tick();
        rst_n = 1;
        tick();
        // R1 reset state
        chk("R1 flags", int'({st_ovl, st_ovt, st_png}), 0);
        chk("R1 vsel", int'(vsel), 0);
        chk("R1 fault_n", int'(fault_n), 1);
        chk("R1 pwr_en", int'(pwr_en), 0);

        write(5, 1, 0);
        chk("R10 enable with vsel", int'(pwr_en), 1);

        // Overload with wipe policy
        ovl_raw = 1; tick();
        chk("R2 overload flag", int'(st_ovl), 1);
        rd_stb = 1; tick();
        chk("R4 read while active", int'(st_ovl), 1);
        ovl_raw = 0; tick(); rd_stb = 0;
        chk("R4 read on release edge", int'(st_ovl), 1);
        chk("R5 vsel wiped", int'(vsel), 0);
        tick();
        chk("R3 holds without read", int'(st_ovl), 1);
        chk("R5 stays wiped", int'(vsel), 0);
        rd_stb = 1; tick(); rd_stb = 0;
        chk("R3 cleared by read", int'(st_ovl), 0);

        // Overload with auto re-arm
        write(3, 0, 0);
        ovl_raw = 1; ol_out_en = 0; tick();
        chk("R6 output off in overload", int'(pwr_en), 0);
        ovl_raw = 0; ol_out_en = 1; tick();
        chk("R6 vsel kept", int'(vsel), 3);
        chk("R6 re-enabled", int'(pwr_en), 1);
        rd_stb = 1; tick(); rd_stb = 0;

        // Thermal with wipe policy
        write(9, 0, 1);
        ovt_raw = 1; #0;
        chk("R7 off during overtemp", int'(pwr_en), 0);
        tick();
        chk("R2 overtemp flag", int'(st_ovt), 1);
        ovt_raw = 0; tick();
        chk("R7 vsel wiped", int'(vsel), 0);
        rd_stb = 1; tick(); rd_stb = 0;

        // Low input power
        png_raw = 1; tick();
        chk("R9 fault pin low", int'(fault_n), 0);
        png_raw = 0; tick();
        chk("R9 still low before read", int'(fault_n), 0);
        rd_stb = 1; tick(); rd_stb = 0;
        chk("R9 released after read", int'(fault_n), 1);

        // Lockout
        png_raw = 1; tick(); png_raw = 0; tick();
        uvlo = 1;
        write(7, 1, 1);
        chk("R8 write ignored", int'(vsel), 0);
        rd_stb = 1; tick(); rd_stb = 0;
        chk("R8 read ignored", int'(st_png), 1);
        uvlo = 0; tick();
        ovl_raw = 1; tick(); ovl_raw = 0; tick();
        chk("R8 policy held at zero", int'(vsel), 0);
        rd_stb = 1; tick(); rd_stb = 0;

        // Wipe on the same edge as a write
        write(4, 1, 0);
        ovl_raw = 1; tick();
        ovl_raw = 0; wr_en = 1; wr_vsel = 4'd6; wr_olr = 1; wr_therm = 0; tick(); wr_en = 0;
        chk("R11 wipe wins", int'(vsel), 0);
        rd_stb = 1; tick(); rd_stb = 0;

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            ovl_raw   = ($urandom % 6) == 0;
            ovt_raw   = ($urandom % 8) == 0;
            png_raw   = ($urandom % 8) == 0;
            ol_out_en = ($urandom % 5) != 0;
            uvlo      = ($urandom % 20) == 0;
            rd_stb    = ($urandom % 3) == 0;
            wr_en     = ($urandom % 4) == 0;
            wr_vsel   = VW'($urandom);
            wr_olr    = $urandom % 2;
            wr_therm  = $urandom % 2;
            tick();
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule